// File: doc/BRIEF.md
# Serial GPIO Expander Master

This block extends a chip's general-purpose I/O by up to 80 lines through two external cascaded shift-register chains. One chain is serial-in/parallel-out and drives outputs. The other is parallel-in/serial-out and gathers inputs. A single repeating frame serves both chains. It first pulses a parallel-load strobe for the input chain, then clocks N bits. Output data moves on the low phase of the serial clock and input data is sampled as the clock rises. A latch strobe then transfers the shifted word to the output chain's pins.

Software reaches the block through an APB slave with no wait states. It sets the pin count in groups of eight, a serial-clock divisor and an enable, and it writes the output words. It reads the input words, which update only once a frame completes. Every input pin has its own interrupt enable and one of four sensitivities. Status bits are sticky and are OR-ed onto one interrupt line. A soft-reset command clears every output bit whose keep bit is not set.

Register words, at byte offsets with 32 pins per word (word g covers pins 32g..32g+31): CONTROL 0x00, OUT 0x10+4g, IN 0x20+4g, IRQ_EN 0x30+4g, SENSE_LO 0x40+4g, SENSE_HI 0x50+4g, STATUS 0x60+4g, KEEP 0x70+4g. The CONTROL fields are: bit 0 enable, bit 1 soft reset (write-only, reads 0), bits 7:4 group count, bits 31:16 divisor D.

Top module: `serial_gpio_master`

## Requirements
- R1: pready is always 1. OUT, IRQ_EN, SENSE_LO, SENSE_HI and KEEP words read back what was written, and writes to the IN words have no effect.
- R2: While shifting, the serial clock has a period of 2*(D+1) bus clocks, so a divisor of 0 gives divide-by-2.
- R3: A frame is: load strobe high for one serial period, then exactly N serial clock pulses carrying OUT bit N-1 first down to bit 0, then latch strobe high for one serial period. Serial data does not change while the serial clock is high.
- R4: After a frame, IN holds the N sampled bits, with the first sampled bit at pin N-1. IN pins at N and above read 0. IN changes only at the end of a frame.
- R5: N = 8 * CONTROL[7:4], and a field above 10 is treated as 10. With enable 0 or a field of 0, the engine stays idle with no strobes and no serial clock. After reset all registers are 0 and the engine is idle.
- R6: Changes to the divisor or pin count take effect only at a frame boundary. The frame in progress keeps its settings.
- R7: Per pin, {SENSE_HI,SENSE_LO} selects the sensitivity: 00 level-high, 01 level-low, 10 rising (previous frame 0, new 1), 11 falling. The previous value is the IN value before the frame.
- R8: A STATUS bit is set at the end of a frame only when its IRQ_EN bit is 1. It stays set until software writes 1 to it. irq is the OR of all STATUS bits.
- R9: Writing 1 to CONTROL bit 1 clears the OUT bits whose KEEP bit is 0, keeps the OUT bits whose KEEP bit is 1, clears STATUS and aborts the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| ser_clk | output | 1 | Serial shift clock to both chains |
| ser_load | output | 1 | Parallel-load strobe to the input chain |
| ser_latch | output | 1 | Output latch strobe to the output chain |
| ser_dout | output | 1 | Serial data to the output chain |
| ser_din | input | 1 | Serial data from the input chain |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check four properties on every cycle. Settings stay frozen while bits shift. Serial data holds steady while the clock is high. The input words and the interrupt line move only at the end of a frame. A soft reset leaves no unprotected output bit set. Other behaviour can only be shown through the bench's scenarios: correct bit order across the chains, the clock period for each divisor, clamping of the pin count, and each of the four sensitivities against edges from one frame to the next. The bench drives behavioural models of both external chains and compares their results with values it predicts.

// File: rtl/serial_gpio_master.sv
module serial_gpio_master #(
  parameter int MAX_PINS = 80,
  parameter int DIV_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        ser_clk,
  output logic        ser_load,
  output logic        ser_latch,
  output logic        ser_dout,
  input  logic        ser_din,
  output logic        irq
);
  localparam int NW    = (MAX_PINS + 31) / 32;
  localparam int PW    = NW * 32;
  localparam int MAX_G = MAX_PINS / 8;
  localparam int CW    = $clog2(PW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_LATCH} st_t;

  logic             en_q;
  logic [3:0]       grp_q;
  logic [DIV_W-1:0] div_q, div_act, hcnt;
  logic [PW-1:0]    out_q, in_q, ien_q, m0_q, m1_q, sts_q, sts_nxt, tol_q;
  logic [PW-1:0]    snap, sh, act_mask, new_v, hit;
  logic [CW-1:0]    n_req, n_act, bcnt;
  st_t              st;
  logic             ph, dout_q;

  logic [5:0] widx;
  logic       wr, srst, tick, frame_end, start_ok;

  assign widx      = paddr[7:2];
  assign wr        = psel && penable && pwrite;
  assign srst      = wr && widx == 6'd0 && pwdata[1];
  assign pready    = 1'b1;
  assign tick      = hcnt == div_act;
  assign frame_end = st == S_LATCH && tick && ph;
  assign n_req     = (grp_q > 4'(MAX_G)) ? CW'(MAX_G * 8) : CW'({grp_q, 3'b000});
  assign start_ok  = en_q && n_req != '0;
  assign ser_clk   = st == S_SHIFT && ph;
  assign ser_load  = st == S_LOAD;
  assign ser_latch = st == S_LATCH;
  assign ser_dout  = dout_q;
  assign irq       = |sts_q;

  logic unused_ok;
  assign unused_ok = &{1'b0, paddr[1:0], sh[PW-1]};

  always_comb
    for (int i = 0; i < PW; i++) act_mask[i] = (i < int'(n_act));

  assign new_v = sh & act_mask;
  assign hit = ien_q & act_mask &
               ((~m1_q & ~m0_q & new_v) | (~m1_q & m0_q & ~new_v) |
                (m1_q & ~m0_q & new_v & ~in_q) | (m1_q & m0_q & ~new_v & in_q));

  always_comb begin
    sts_nxt = sts_q;
    for (int g = 0; g < NW; g++)
      if (wr && widx == 6'(24 + g)) sts_nxt[32*g +: 32] = sts_q[32*g +: 32] & ~pwdata;
    if (srst) sts_nxt = '0;
    else if (frame_end) sts_nxt = sts_nxt | hit;
  end

  always_comb begin
    int gsel;
    gsel = int'(widx[1:0]);
    prdata = '0;
    if (widx == 6'd0) begin
      prdata[0]          = en_q;
      prdata[7:4]        = grp_q;
      prdata[16 +: DIV_W] = div_q;
    end else if (gsel < NW) begin
      case (widx[5:2])
        4'd1:    prdata = out_q[32*gsel +: 32];
        4'd2:    prdata = in_q[32*gsel +: 32];
        4'd3:    prdata = ien_q[32*gsel +: 32];
        4'd4:    prdata = m0_q[32*gsel +: 32];
        4'd5:    prdata = m1_q[32*gsel +: 32];
        4'd6:    prdata = sts_q[32*gsel +: 32];
        4'd7:    prdata = tol_q[32*gsel +: 32];
        default: prdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; grp_q <= '0; div_q <= '0;
      out_q <= '0; in_q <= '0; ien_q <= '0; m0_q <= '0; m1_q <= '0;
      sts_q <= '0; tol_q <= '0;
    end else begin
      if (wr && widx == 6'd0) begin
        en_q  <= pwdata[0];
        grp_q <= pwdata[7:4];
        div_q <= pwdata[16 +: DIV_W];
      end
      for (int g = 0; g < NW; g++) begin
        if (wr && widx == 6'(4 + g))  out_q[32*g +: 32] <= pwdata;
        if (wr && widx == 6'(12 + g)) ien_q[32*g +: 32] <= pwdata;
        if (wr && widx == 6'(16 + g)) m0_q[32*g +: 32]  <= pwdata;
        if (wr && widx == 6'(20 + g)) m1_q[32*g +: 32]  <= pwdata;
        if (wr && widx == 6'(28 + g)) tol_q[32*g +: 32] <= pwdata;
      end
      if (srst) out_q <= out_q & tol_q;
      if (frame_end && !srst) in_q <= new_v;
      sts_q <= sts_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; hcnt <= '0; bcnt <= '0; n_act <= '0;
      div_act <= '0; snap <= '0; sh <= '0; dout_q <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; ph <= 1'b0; hcnt <= '0; dout_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start_ok) begin
        st <= S_LOAD; n_act <= n_req; div_act <= div_q; snap <= out_q;
        hcnt <= '0; ph <= 1'b0;
      end
    end else if (!tick) begin
      hcnt <= hcnt + 1'b1;
    end else begin
      hcnt <= '0;
      ph   <= ~ph;
      if (!ph && st == S_SHIFT) sh <= {sh[PW-2:0], ser_din};
      if (ph) begin
        case (st)
          S_LOAD: begin
            st <= S_SHIFT; bcnt <= n_act - 1'b1; dout_q <= snap[n_act - 1'b1];
          end
          S_SHIFT:
            if (bcnt == '0) begin
              st <= S_LATCH; dout_q <= 1'b0;
            end else begin
              bcnt <= bcnt - 1'b1; dout_q <= snap[bcnt - 1'b1];
            end
          S_LATCH:
            if (start_ok) begin
              st <= S_LOAD; n_act <= n_req; div_act <= div_q; snap <= out_q;
            end else st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SHIFT |-> $stable(n_act) && $stable(div_act));

  assert_dout_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dout));

  assert_in_at_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_q) |-> $past(st == S_LATCH));

  assert_irq_from_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(st == S_LATCH));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (out_q & ~tol_q) == '0);
endmodule

// File: tb/tb_serial_gpio_master.sv
module tb_serial_gpio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic psel = 0, penable = 0, pwrite = 0, ser_din;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, ser_clk, ser_load, ser_latch, ser_dout, irq;

  serial_gpio_master dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .ser_clk(ser_clk), .ser_load(ser_load), .ser_latch(ser_latch),
    .ser_dout(ser_dout), .ser_din(ser_din), .irq(irq));

  int nchk = 0, nfail = 0, cyc = 0;
  int n_ext = 8, pulses = 0, frame_pulses = 0, last_rise = 0, last_per = 0, loads = 0;
  logic [95:0] pins = '0, ichain = '0, ochain = '0, opar = '0;

  always @(posedge clk) cyc++;

  assign ser_din = (n_ext > 0) ? ichain[n_ext-1] : 1'b0;

  always @(posedge ser_load or posedge ser_clk or posedge ser_latch) begin
    if (ser_load) begin
      ichain <= pins; pulses = 0; loads++;
    end else if (ser_latch) begin
      opar <= ochain; frame_pulses = pulses;
    end else begin
      ochain <= {ochain[94:0], ser_dout};
      ichain <= ichain << 1;
      if (pulses > 0) last_per = cyc - last_rise;
      last_rise = cyc;
      pulses++;
    end
  end

  task automatic chk(input string what, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic wvec(input logic [7:0] base, input logic [95:0] v);
    for (int g = 0; g < 3; g++) apb_write(base + 8'(4*g), v[32*g +: 32]);
  endtask

  task automatic rvec(input logic [7:0] base, output logic [95:0] v);
    logic [31:0] d;
    for (int g = 0; g < 3; g++) begin
      apb_read(base + 8'(4*g), d);
      v[32*g +: 32] = d;
    end
  endtask

  task automatic set_ctrl(input int en, input int grp, input int dv, input int sr);
    apb_write(8'h00, {16'(dv), 8'h00, 4'(grp), 2'b00, 1'(sr), 1'(en)});
  endtask

  function automatic logic [95:0] nmask(input int n);
    logic [95:0] m;
    for (int i = 0; i < 96; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [95:0] hits(input logic [95:0] nw, od, lo, hi, ie);
    return ie & ((~hi & ~lo & nw) | (~hi & lo & ~nw) | (hi & ~lo & nw & ~od) | (hi & lo & ~nw & od));
  endfunction

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [95:0] v, got;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state, engine idle
    apb_read(8'h00, d); chk("R5 ctrl after reset", d, 0);
    rvec(8'h10, got); chk("R5 out after reset", got, 0);
    chk("R5 strobes idle after reset", {ser_clk, ser_load, ser_latch, irq}, 0);
    chk("R1 pready", pready, 1);

    // R1: read-back and read-only words
    v = rnd96(); wvec(8'h30, v); rvec(8'h30, got); chk("R1 irq_en readback", got, v);
    v = rnd96(); wvec(8'h40, v); rvec(8'h40, got); chk("R1 sense_lo readback", got, v);
    v = rnd96(); wvec(8'h50, v); rvec(8'h50, got); chk("R1 sense_hi readback", got, v);
    v = rnd96(); wvec(8'h70, v); rvec(8'h70, got); chk("R1 keep readback", got, v);
    v = rnd96(); wvec(8'h10, v); rvec(8'h10, got); chk("R1 out readback", got, v);
    wvec(8'h20, rnd96()); rvec(8'h20, got); chk("R1 in ignores writes", got, 0);
    wvec(8'h30, '0);

    // R2 R3 R4: random frames, with clamp and divide-by-2 corners
    for (int it = 0; it < 12; it++) begin
      int g, dv, n;
      logic [95:0] ov, iv, m;
      g  = (it == 0) ? 15 : $urandom_range(10, 1);
      dv = (it == 1) ? 0 : $urandom_range(3, 0);
      n  = 8 * ((g > 10) ? 10 : g);
      m  = nmask(n);
      n_ext = n;
      ov = rnd96(); iv = rnd96();
      wvec(8'h10, ov);
      pins = iv;
      set_ctrl(1, g, dv, 0);
      @(posedge ser_load); @(posedge ser_load); @(negedge clk);
      chk("R3 output chain contents", opar & m, ov & m);
      chk("R3 R5 pulses per frame", frame_pulses, n);
      chk("R2 serial clock period", last_per, 2 * (dv + 1));
      rvec(8'h20, got);
      chk("R4 input capture", got, iv & m);
    end

    // R6: pin count change lands at the frame boundary
    n_ext = 16;
    set_ctrl(1, 2, 1, 0);
    @(posedge ser_load); @(posedge ser_load); @(negedge clk);
    set_ctrl(1, 4, 1, 0);
    @(posedge ser_latch); @(negedge clk);
    chk("R6 current frame keeps count", frame_pulses, 16);
    @(posedge ser_latch); @(negedge clk);
    chk("R6 next frame uses new count", frame_pulses, 32);

    // R5: disabled and zero-count engines stay idle
    set_ctrl(0, 2, 0, 0);
    repeat (200) @(negedge clk);
    d = 32'(loads);
    repeat (300) @(negedge clk);
    chk("R5 disabled engine idle", 32'(loads), d);
    set_ctrl(1, 0, 0, 0);
    repeat (200) @(negedge clk);
    chk("R5 zero count idle", {32'(loads), 1'b0}, {d, ser_clk});

    // R7 R8: sensitivities against frame-to-frame changes
    n_ext = 32;
    set_ctrl(1, 4, 0, 0);
    for (int it = 0; it < 8; it++) begin
      logic [95:0] ie, lo, hi, od, nw, ex;
      ie = (it == 0) ? '0 : rnd96();
      lo = (it == 1) ? '0 : rnd96();
      hi = (it == 1) ? '1 : rnd96();
      od = {64'h0, $urandom}; nw = {64'h0, $urandom};
      wvec(8'h30, ie); wvec(8'h40, lo); wvec(8'h50, hi);
      pins = od;
      @(posedge ser_load); @(posedge ser_load); @(negedge clk);
      pins = nw;
      @(posedge ser_load);
      wvec(8'h60, '1);
      @(posedge ser_load); @(negedge clk);
      ex = hits(nw, od, lo, hi, ie) & nmask(32);
      rvec(8'h60, got);
      chk("R7 status after frame", got, ex);
      chk("R8 irq is OR of status", irq, |ex);
      wvec(8'h60, '1);
      rvec(8'h60, got);
      chk("R8 write-1-to-clear", got, 0);
      chk("R8 irq low after clear", irq, 0);
    end

    // R9: soft reset keeps only protected outputs
    v = rnd96(); wvec(8'h10, v);
    got = rnd96(); wvec(8'h70, got);
    pins = '1; wvec(8'h30, '1); wvec(8'h40, '0); wvec(8'h50, '0);
    @(posedge ser_load); @(posedge ser_load); @(negedge clk);
    set_ctrl(1, 4, 0, 1);
    begin
      logic [95:0] o2, s2;
      rvec(8'h10, o2); chk("R9 unprotected outputs cleared", o2, v & got);
      rvec(8'h60, s2); chk("R9 status cleared", s2, 0);
      apb_read(8'h00, d); chk("R9 soft reset bit reads 0", d, 32'h0000_0041);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule